// File: doc/BRIEF.md
# Correlation Model Peak Picker

This block takes one bit period's worth of signed correlation estimates (256 points by default), finds the points where a multipath echo most likely arrived, and turns them into per-correlator control entries. The search runs on the rectified value of each estimate. The sign of every chosen point is kept, so a correlator later multiplies the received pulse by the right polarity. Local maxima whose magnitude falls below a programmable threshold are treated as noise and dropped. The strongest surviving point is reported as the direct path. Downstream logic uses it to place the bit boundary, and correlator reset is scheduled just ahead of that point.

The estimates arrive one per valid beat, in interval order, after a start pulse. Once the last estimate is in, every point is tested in parallel. A registered comparison tree then narrows the accepted points down to the strongest one. The finished flag rises a fixed nine cycles later, which keeps the search inside a ten-cycle budget. The control map is laid out per correlator. With 16 correlators each covering 16 intervals, interval i belongs to correlator i mod 16 in slot i div 16.

Top module: `echo_peak_picker`

## Requirements
- R1: After reset or a start pulse, successive `est_valid` beats load estimates for intervals 0, 1, 2 … 255 in order. Beats after the 256th are ignored until the next start.
- R2: A point is a peak when its magnitude is strictly greater than that of its left neighbour and at least that of its right neighbour. Neighbours are circular: interval 0's left neighbour is 255, and interval 255's right neighbour is 0. Of two equal adjacent maxima, only the lower-index one is a peak.
- R3: A peak is accepted only when its magnitude is greater than or equal to `thresh`, read as unsigned. A weaker local maximum is dropped.
- R4: The control entry of an accepted peak is 2'b01 (+1) when its estimate is positive and 2'b11 (-1) when it is negative. Every other entry is 2'b00. The code 2'b10 never appears.
- R5: The entry for interval i is at `ctrl_map` bits [2p+1:2p], with p = 16·(i mod 16) + (i div 16). This places correlator c's sixteen slots contiguously, with slot 0 lowest.
- R6: `peak_idx` is the index of the accepted peak with the largest magnitude, and equal magnitudes resolve to the lowest index. `peak_found` is 1 exactly when at least one peak was accepted. With no accepted peak, `peak_idx` is 0 and the map is all zero.
- R7: `done` rises on the ninth rising edge after the edge that accepts the 256th estimate. The map, `peak_idx` and `peak_found` are valid and steady while `done` is high.
- R8: A start pulse clears `done` on the next rising edge, and `done` stays high until then.
- R9: After reset, `done`, `peak_found`, `peak_idx` and the whole map are zero.
- R10: The most negative estimate, -2048 for 12-bit estimates, has magnitude 2048 and outranks +2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a new model load and clears the finished flag |
| est_valid | input | 1 | Estimate beat qualifier |
| est_data | input | EST_W (12) | Signed two's-complement correlation estimate |
| thresh | input | EST_W (12) | Unsigned acceptance threshold on magnitude; hold it from the last beat until done |
| done | output | 1 | Search finished, results valid |
| peak_found | output | 1 | At least one peak was accepted |
| peak_idx | output | log2(NPTS) (8) | Interval of the strongest accepted peak |
| ctrl_map | output | 2·NPTS (512) | Per-correlator polarity entries, two bits each |

## Verification
On every cycle, the assertions check the following. The code 2'b10 never appears in the map. The map entry addressed by `peak_idx` is non-zero whenever a peak is reported. An empty result leaves the map clear. `done` rises exactly nine cycles after the final accepted beat, and it falls only after a start pulse. Results hold steady while `done` is high. Only the bench's scenarios can show the decision rules themselves: the circular-neighbour test, plateau tie-breaking, the inclusive threshold, polarity under mixed signs, the lowest-index tie among equal strongest peaks, the most negative estimate, and extra beats being ignored. Each scenario is compared against a model computed in the bench.

// File: rtl/epp_pkg.sv
// Shared constants for the correlation model peak picker.
// Assumes control entries are two-bit two's-complement polarity codes.
package epp_pkg;
    typedef logic [1:0] map_code_t;
    localparam map_code_t MAP_ZERO = 2'b00;
    localparam map_code_t MAP_POS  = 2'b01;
    localparam map_code_t MAP_NEG  = 2'b11;
endpackage

// File: rtl/epp_model_buf.sv
// Model buffer: captures NPTS signed estimates in arrival order.
// Assumes beats arrive in interval order; start (or reset) rewinds the
// write pointer; beats past the last slot are dropped. Emits a one-cycle
// go pulse on the edge that stores the final estimate.
module epp_model_buf #(
    parameter int EST_W = 12,
    parameter int NPTS  = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    est_valid,
    input  logic [EST_W-1:0]        est_data,
    output logic signed [EST_W-1:0] model [NPTS],
    output logic                    go
);
    localparam int IW = $clog2(NPTS);
    localparam int PW = $clog2(NPTS + 1);

    logic [PW-1:0] wr_ptr;
    logic          full;

    assign full = (wr_ptr == PW'(NPTS));

    // Store estimates and advance the write pointer; flag the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            go     <= 1'b0;
            for (int k = 0; k < NPTS; k++) model[k] <= '0;
        end else begin
            go <= 1'b0;
            if (start) begin
                wr_ptr <= '0;
            end else if (est_valid && !full) begin
                model[wr_ptr[IW-1:0]] <= $signed(est_data);
                wr_ptr                <= wr_ptr + 1'b1;
                go                    <= (wr_ptr == PW'(NPTS - 1));
            end
        end
    end
endmodule

// File: rtl/epp_peak_find.sv
// Parallel peak finder: rectifies every estimate, tests each point against
// its circular neighbours, applies the threshold and registers the control
// map plus one leaf candidate per point when load is high.
// Assumes NPTS is a multiple of NCORR.
module epp_peak_find
    import epp_pkg::*;
#(
    parameter int EST_W = 12,
    parameter int NPTS  = 256,
    parameter int NCORR = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [EST_W-1:0]        thresh,
    input  logic signed [EST_W-1:0] model [NPTS],
    output logic [NPTS-1:0]         leaf_found,
    output logic [EST_W-1:0]        leaf_mag [NPTS],
    output logic [2*NPTS-1:0]       ctrl_map
);
    localparam int NSLOT = NPTS / NCORR;

    logic [EST_W-1:0]  mag [NPTS];
    logic [NPTS-1:0]   accept;
    logic [2*NPTS-1:0] map_next;

    // Rectify each estimate; the most negative code maps to 2^(EST_W-1).
    always_comb begin
        for (int k = 0; k < NPTS; k++) begin
            mag[k] = model[k][EST_W-1] ? $unsigned(-model[k]) : $unsigned(model[k]);
        end
    end

    for (genvar i = 0; i < NPTS; i++) begin : g_pt
        localparam int LEFT  = (i + NPTS - 1) % NPTS;
        localparam int RIGHT = (i + 1) % NPTS;
        localparam int POS   = (i % NCORR) * NSLOT + (i / NCORR);
        // Local maximum with left-side tie break, then threshold gate.
        assign accept[i] = (mag[i] > mag[LEFT]) && (mag[i] >= mag[RIGHT]) && (mag[i] >= thresh);
        // Polarity code placed at the correlator/slot position.
        assign map_next[2*POS +: 2] = !accept[i]        ? MAP_ZERO :
                                      model[i][EST_W-1] ? MAP_NEG  : MAP_POS;
    end

    // Capture map and leaf candidates once the model is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leaf_found <= '0;
            ctrl_map   <= '0;
            for (int k = 0; k < NPTS; k++) leaf_mag[k] <= '0;
        end else if (load) begin
            leaf_found <= accept;
            ctrl_map   <= map_next;
            for (int k = 0; k < NPTS; k++) leaf_mag[k] <= mag[k];
        end
    end
endmodule

// File: rtl/epp_max_tree.sv
// Registered maximum tree: a heap of NPTS-1 comparison nodes, one level
// per cycle, that picks the strongest found candidate. The root settles
// log2(NPTS) cycles after the leaves change. Ties resolve to the lower
// index. Assumes NPTS is a power of two.
module epp_max_tree #(
    parameter int NPTS  = 256,
    parameter int MAG_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPTS-1:0]          leaf_found,
    input  logic [MAG_W-1:0]         leaf_mag [NPTS],
    output logic                     best_found,
    output logic [$clog2(NPTS)-1:0]  best_idx
);
    localparam int IW    = $clog2(NPTS);
    localparam int NODES = NPTS - 1;
    localparam int TOTAL = 2 * NPTS - 1;

    typedef struct packed {
        logic             found;
        logic [MAG_W-1:0] mag;
        logic [IW-1:0]    idx;
    } cand_t;

    cand_t node_q [NODES];
    cand_t all_c  [TOTAL];

    // Left operand covers lower indices, so it wins on equal magnitude.
    function automatic cand_t pick(input cand_t a, input cand_t b);
        if (a.found && (!b.found || a.mag >= b.mag)) return a;
        return b;
    endfunction

    // Flatten internal nodes and leaves into one heap view.
    always_comb begin
        for (int n = 0; n < NODES; n++) all_c[n] = node_q[n];
        for (int k = 0; k < NPTS; k++) begin
            all_c[NODES + k].found = leaf_found[k];
            all_c[NODES + k].mag   = leaf_mag[k];
            all_c[NODES + k].idx   = leaf_found[k] ? IW'(k) : '0;
        end
    end

    // Advance every tree level by one comparison per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NODES; n++) node_q[n] <= '0;
        end else begin
            for (int n = 0; n < NODES; n++) node_q[n] <= pick(all_c[2*n+1], all_c[2*n+2]);
        end
    end

    assign best_found = node_q[0].found;
    assign best_idx   = node_q[0].idx;
endmodule

// File: rtl/echo_peak_picker.sv
// Top of the correlation model peak picker. Loads a bit period of signed
// estimates, finds thresholded circular local maxima on magnitude, writes
// signed per-correlator control entries and reports the strongest peak.
// done rises a fixed log2(NPTS)+1 cycles after the final estimate.
// Assumes NPTS is a power of two and a multiple of NCORR.
module echo_peak_picker #(
    parameter int EST_W = 12,
    parameter int NPTS  = 256,
    parameter int NCORR = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     est_valid,
    input  logic [EST_W-1:0]         est_data,
    input  logic [EST_W-1:0]         thresh,
    output logic                     done,
    output logic                     peak_found,
    output logic [$clog2(NPTS)-1:0]  peak_idx,
    output logic [2*NPTS-1:0]        ctrl_map
);
    localparam int DEPTH = $clog2(NPTS);

    logic signed [EST_W-1:0] model [NPTS];
    logic                    go;
    logic [NPTS-1:0]         leaf_found;
    logic [EST_W-1:0]        leaf_mag [NPTS];
    logic [DEPTH-1:0]        stage_q;

    epp_model_buf #(.EST_W(EST_W), .NPTS(NPTS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .est_valid (est_valid),
        .est_data  (est_data),
        .model     (model),
        .go        (go)
    );

    epp_peak_find #(.EST_W(EST_W), .NPTS(NPTS), .NCORR(NCORR)) u_find (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (go),
        .thresh     (thresh),
        .model      (model),
        .leaf_found (leaf_found),
        .leaf_mag   (leaf_mag),
        .ctrl_map   (ctrl_map)
    );

    epp_max_tree #(.NPTS(NPTS), .MAG_W(EST_W)) u_tree (
        .clk        (clk),
        .rst_n      (rst_n),
        .leaf_found (leaf_found),
        .leaf_mag   (leaf_mag),
        .best_found (peak_found),
        .best_idx   (peak_idx)
    );

    // Track the search through the tree levels and raise a sticky done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            done    <= 1'b0;
        end else if (start) begin
            stage_q <= '0;
            done    <= 1'b0;
        end else begin
            stage_q <= {stage_q[DEPTH-2:0], go};
            if (stage_q[DEPTH-1]) done <= 1'b1;
        end
    end
endmodule

// File: rtl/epp_chk.sv
// Checker for echo_peak_picker: map encoding, result consistency, fixed
// search latency, result stability and done clearing.
module epp_chk #(
    parameter int EST_W = 12,
    parameter int NPTS  = 256,
    parameter int NCORR = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    est_valid,
    input logic                    done,
    input logic                    peak_found,
    input logic [$clog2(NPTS)-1:0] peak_idx,
    input logic [2*NPTS-1:0]       ctrl_map
);
    localparam int IW    = $clog2(NPTS);
    localparam int NSLOT = NPTS / NCORR;
    localparam int LAT   = IW + 1;
    localparam int CW    = $clog2(NPTS + 1);
    localparam int LW    = $clog2(LAT + 2);

    logic [CW-1:0] beat_cnt;
    logic [LW-1:0] lat_q;
    logic          timing;

    function automatic logic has_bad_code(input logic [2*NPTS-1:0] m);
        for (int k = 0; k < NPTS; k++) if (m[2*k +: 2] == 2'b10) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [1:0] entry_at(input logic [2*NPTS-1:0] m, input logic [IW-1:0] ix);
        int c;
        int s;
        c = int'(ix) % NCORR;
        s = int'(ix) / NCORR;
        return m[2*(c*NSLOT + s) +: 2];
    endfunction

    // Count accepted beats and time the search from the final one.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            beat_cnt <= '0;
            lat_q    <= '0;
            timing   <= 1'b0;
        end else begin
            if (est_valid && beat_cnt < CW'(NPTS)) beat_cnt <= beat_cnt + 1'b1;
            if (est_valid && beat_cnt == CW'(NPTS - 1)) begin
                timing <= 1'b1;
                lat_q  <= '0;
            end else if (timing && lat_q != LW'(LAT + 1)) begin
                lat_q <= lat_q + 1'b1;
            end
        end
    end

    // R4
    map_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !has_bad_code(ctrl_map));
    // R6
    best_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && peak_found) |-> (entry_at(ctrl_map, peak_idx) != 2'b00));
    // R6
    empty_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !peak_found) |-> (ctrl_map == '0 && peak_idx == '0));
    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (timing && lat_q == LW'(LAT)));
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(ctrl_map) && $stable(peak_idx) && $stable(peak_found)));
    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));
endmodule

bind echo_peak_picker epp_chk #(.EST_W(EST_W), .NPTS(NPTS), .NCORR(NCORR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .est_valid  (est_valid),
    .done       (done),
    .peak_found (peak_found),
    .peak_idx   (peak_idx),
    .ctrl_map   (ctrl_map)
);

// File: tb/echo_peak_picker_bench.sv
module echo_peak_picker_bench;
    localparam int N = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        est_valid = 1'b0;
    logic [11:0] est_data = '0;
    logic [11:0] thresh = '0;
    logic        done;
    logic        peak_found;
    logic [7:0]  peak_idx;
    logic [511:0] ctrl_map;

    typedef struct {
        logic [511:0] map;
        logic [7:0]   idx;
        logic         found;
        int           due;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   seed = 7;
    logic signed [11:0] pat [N];

    echo_peak_picker u_echo_peak_picker (
        .clk(clk), .rst_n(rst_n), .start(start), .est_valid(est_valid),
        .est_data(est_data), .thresh(thresh), .done(done),
        .peak_found(peak_found), .peak_idx(peak_idx), .ctrl_map(ctrl_map)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Reference result built straight from the requirement text.
    function automatic exp_t build_expect(input int thr, input string tag);
        exp_t e;
        int best_m;
        e.map = '0;
        e.idx = '0;
        e.found = 1'b0;
        e.tag = tag;
        e.due = 0;
        best_m = -1;
        for (int i = 0; i < N; i++) begin
            int v, vl, vr, m, ml, mr, p;
            v  = pat[i];
            vl = pat[(i + N - 1) % N];
            vr = pat[(i + 1) % N];
            m  = v  < 0 ? -v  : v;
            ml = vl < 0 ? -vl : vl;
            mr = vr < 0 ? -vr : vr;
            if (m > ml && m >= mr && m >= thr) begin
                p = (i % 16) * 16 + i / 16;
                e.map[2*p +: 2] = (v < 0) ? 2'b11 : 2'b01;
                if (m > best_m) begin
                    best_m = m;
                    e.idx = 8'(i);
                end
                e.found = 1'b1;
            end
        end
        return e;
    endfunction

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'hfff;
    endfunction

    task automatic clear_pat();
        for (int i = 0; i < N; i++) pat[i] = '0;
    endtask

    // Driver: start, stream the model, push the expected result.
    task automatic run_case(input int thr, input int extra, input string tag);
        exp_t e;
        bit was_done;
        @(negedge clk);
        start = 1'b1;
        was_done = done;
        @(negedge clk);
        start = 1'b0;
        if (was_done) check(done == 1'b0, "R8", {tag, " done cleared by start"}, 512'(done), 512'(0));
        thresh = 12'(thr);
        e = build_expect(thr, tag);
        for (int k = 0; k < N; k++) begin
            est_valid = 1'b1;
            est_data = pat[k];
            if (k == N - 1) begin
                e.due = cyc + 10;
                exp_q.push_back(e);
            end
            @(negedge clk);
        end
        for (int k = 0; k < extra; k++) begin
            est_data = 12'(k[0] ? 2000 : -2000);
            @(negedge clk);
        end
        est_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: on each new done, pop the expected item and compare.
    initial begin
        bit seen = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done && !seen) begin
                seen = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "done without pending search", 512'(done), 512'(0));
                end else begin
                    e = exp_q.pop_front();
                    check(cyc == e.due, "R7", {e.tag, " done cycle"}, 512'(cyc), 512'(e.due));
                    check(ctrl_map == e.map, "R2 R3 R4 R5", {e.tag, " control map"}, ctrl_map, e.map);
                    check(peak_idx == e.idx, "R6", {e.tag, " strongest index"}, 512'(peak_idx), 512'(e.idx));
                    check(peak_found == e.found, "R6", {e.tag, " peak found"}, 512'(peak_found), 512'(e.found));
                end
            end
            if (!done) seen = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog expired: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(done == 1'b0, "R9", "reset done", 512'(done), 512'(0));
        check(peak_found == 1'b0, "R9", "reset found", 512'(peak_found), 512'(0));
        check(peak_idx == 8'd0, "R9", "reset index", 512'(peak_idx), 512'(0));
        check(ctrl_map == '0, "R9", "reset map", ctrl_map, 512'(0));

        clear_pat();                                   // R6 empty model
        run_case(1, 0, "zeros");

        clear_pat(); pat[37] = 300;                    // R4 R5 single positive
        run_case(100, 0, "single");

        clear_pat(); pat[10] = 200; pat[200] = -600;   // R4 negative strongest
        run_case(50, 0, "mixed sign");

        clear_pat(); pat[100] = 5; pat[140] = 40; pat[60] = 10;  // R3 weak and equal
        run_case(10, 0, "threshold");

        clear_pat(); pat[50] = 80; pat[51] = 80;       // R2 plateau
        run_case(1, 0, "plateau");

        clear_pat(); pat[255] = 30; pat[0] = 20; pat[128] = -25; pat[1] = 0;  // R2 wrap
        run_case(1, 0, "wrap");

        clear_pat(); pat[0] = 70; pat[255] = 10;       // R2 wrap, index 0 peak
        run_case(1, 0, "wrap zero");

        clear_pat(); pat[30] = -90; pat[150] = 90;     // R6 tie lowest index
        run_case(5, 0, "tie");

        clear_pat(); pat[128] = -2048; pat[20] = 2047; // R10 extreme code
        run_case(100, 0, "extreme");

        for (int i = 0; i < N; i++) pat[i] = 12'(next_rand());  // R2 R3 random
        run_case(1500, 0, "random high thr");
        run_case(0, 0, "random zero thr");

        clear_pat(); pat[77] = -500; pat[3] = 120;     // R1 extra beats ignored
        run_case(60, 20, "extra beats");

        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R8", "final start clears done", 512'(done), 512'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule